// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority Cell

This block is one peripheral's slice of a serial interrupt-priority chain. Cells are wired in a line: each cell's enable-out drives the enable-in of the next cell, and the first cell's enable-in is tied high. The cell's position in the line sets its priority. A cell that is waiting for service, or is being serviced, pulls its enable-out low. That blocks every cell further down the line.

A rising edge on the local request input marks the cell pending. While pending and enabled from above, the cell pulls its active-low request line to the CPU. When the CPU strobes acknowledge, the single enabled pending cell drives its vector onto the data bus in that same cycle and becomes in-service. A return-from-interrupt indication ends service in the in-service cell whose enable-in is high, which is the innermost nested level. A higher-priority cell may still win while a lower one is in service, so service levels nest.

Top module: `prio_chain_cell`

## Requirements
- R1: After reset the cell is neither pending nor in service: `irq_n` is 1, `vec_oe` is 0 and `en_out` equals `en_in`.
- R2: A 0-to-1 transition of `irq_req`, seen at a clock edge, makes the cell pending from that edge on. Holding `irq_req` at 1 does not create a second request. A pending cell that is not in service drives `irq_n` to 0 only while `en_in` is 1.
- R3: `en_out` is 0 whenever `en_in` is 0. With neither pending nor in-service state, `en_out` equals `en_in`.
- R4: While the cell is pending or in service, `en_out` is 0.
- R5: With `ack` at 1, `en_in` at 1 and the cell pending but not in service, the cell sets `vec_oe` to 1 in the same cycle and drives `vec_out` = {`vec_cfg`, 1'b0}. At that clock edge it leaves the pending state and enters service.
- R6: An `ack` while `en_in` is 0, or while the cell is not pending, gives `vec_oe` = 0 and leaves the cell's state unchanged.
- R7: `reti` ends service only in a cell whose `en_in` is 1. After that edge `en_out` again follows `en_in`. In-service cells lower in the chain stay in service.
- R8: While a cell is in service, a higher-priority cell can become pending, request and win an `ack`. That nests a new service level.
- R9: A request edge that arrives while the cell is in service is held pending with `irq_n` at 1. The cell requests again as soon as its service ends.
- R10: `vec_out` bit 0 is always 0, and `vec_out` is all zeros whenever `vec_oe` is 0, so the cells' vectors can be OR-ed onto one bus.
- R11: When several cells are pending at once, only the cell nearest the tied-high end of the chain answers an `ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 1 | Local interrupt request from the peripheral function; its rising edge marks the cell pending |
| en_in | input | 1 | Enable from the higher-priority neighbour; tied high on the first cell |
| ack | input | 1 | CPU interrupt-acknowledge strobe, shared by the whole chain |
| reti | input | 1 | Return-from-interrupt indication, shared by the whole chain |
| vec_cfg | input | VEC_W-1 | Upper bits of this cell's vector |
| irq_n | output | 1 | Active-low request to the CPU; wired-AND across the chain |
| en_out | output | 1 | Enable to the lower-priority neighbour |
| vec_out | output | VEC_W | Vector for the data bus; zero unless driving |
| vec_oe | output | 1 | High while this cell drives its vector |

## Verification
The bench builds four cells with the default `VEC_W` of 8. Each cell gets a distinct `vec_cfg`, so the vectors 0x20, 0x22, 0x24 and 0x26 identify which position answered. Four positions are enough to reach three things: a blocked cell at the far end of the chain, two cells pending together, and a two-level nest whose inner return must leave the outer cell in service. Returning twice from one nest, and a fresh request edge on a cell already in service, cover the return and re-request corners.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    // Per-cell service state: a captured request that has not yet been
    // acknowledged, and an acknowledged request whose service is running.
    typedef struct packed {
        logic pending;
        logic insvc;
    } cell_state_t;

    localparam cell_state_t CELL_IDLE = '{pending: 1'b0, insvc: 1'b0};

endpackage

// File: rtl/pcc_req_edge.sv
module pcc_req_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic rise_o
);
    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = req_i;
        rise_o    = req_i & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{prev: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pcc_svc_ctrl.sv
module pcc_svc_ctrl
    import pcc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rise_i,
    input  logic        en_in_i,
    input  logic        ack_i,
    input  logic        reti_i,
    output cell_state_t st_o,
    output logic        win_o
);
    cell_state_t st_d, st_q;
    logic        win;
    logic        leave;

    always_comb begin
        // A cell answers only when enabled from above, holding a request,
        // and not already in service.
        win   = ack_i & en_in_i & st_q.pending & ~st_q.insvc;
        // Only the innermost in-service level sees en_in high.
        leave = reti_i & en_in_i & st_q.insvc;

        st_d         = st_q;
        st_d.pending = (st_q.pending & ~win) | rise_i;
        st_d.insvc   = (st_q.insvc & ~leave) | win;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CELL_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign st_o  = st_q;
    assign win_o = win;
endmodule

// File: rtl/pcc_chain_gate.sv
module pcc_chain_gate
    import pcc_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic              en_in_i,
    input  cell_state_t       st_i,
    input  logic              win_i,
    input  logic [VEC_W-2:0]  vec_cfg_i,
    output logic              en_out_o,
    output logic              irq_n_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              vec_oe_o
);
    localparam logic [VEC_W-1:0] VEC_ZERO = '0;

    always_comb begin
        en_out_o = en_in_i & ~st_i.pending & ~st_i.insvc;
        irq_n_o  = ~(st_i.pending & ~st_i.insvc & en_in_i);
        vec_oe_o = win_i;
        vec_o    = win_i ? {vec_cfg_i, 1'b0} : VEC_ZERO;
    end
endmodule

// File: rtl/prio_chain_cell.sv
module prio_chain_cell
    import pcc_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_req,
    input  logic             en_in,
    input  logic             ack,
    input  logic             reti,
    input  logic [VEC_W-2:0] vec_cfg,
    output logic             irq_n,
    output logic             en_out,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_oe
);
    logic        req_rise;
    cell_state_t cell_st;
    logic        cell_win;

    pcc_req_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (irq_req),
        .rise_o (req_rise)
    );

    pcc_svc_ctrl u_svc (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (req_rise),
        .en_in_i (en_in),
        .ack_i   (ack),
        .reti_i  (reti),
        .st_o    (cell_st),
        .win_o   (cell_win)
    );

    pcc_chain_gate #(.VEC_W(VEC_W)) u_gate (
        .en_in_i   (en_in),
        .st_i      (cell_st),
        .win_i     (cell_win),
        .vec_cfg_i (vec_cfg),
        .en_out_o  (en_out),
        .irq_n_o   (irq_n),
        .vec_o     (vec_out),
        .vec_oe_o  (vec_oe)
    );
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_in,
    input logic             ack,
    input logic             irq_n,
    input logic             en_out,
    input logic [VEC_W-1:0] vec_out,
    input logic             vec_oe
);
    assert_blocked_passes_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_in |-> !en_out);

    assert_no_request_when_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_in |-> irq_n);

    assert_answer_needs_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> (ack && en_in && !irq_n));

    assert_hold_after_win_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |=> !en_out);

    assert_vec_bit0_R10: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> !vec_out[0]);

    assert_vec_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_oe |-> (vec_out == '0));
endmodule

bind prio_chain_cell pcc_checker #(.VEC_W(VEC_W)) u_pcc_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_in   (en_in),
    .ack     (ack),
    .irq_n   (irq_n),
    .en_out  (en_out),
    .vec_out (vec_out),
    .vec_oe  (vec_oe)
);

// File: tb/test_prio_chain_cell.sv
`timescale 1ns/1ps
module test_prio_chain_cell;
    localparam int N     = 4;
    localparam int VEC_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     req = '0;
    logic             ack = 1'b0;
    logic             reti = 1'b0;
    logic [N:0]       en;
    logic [N-1:0]     irq_n_v;
    logic [N-1:0]     oe_v;
    logic [VEC_W-1:0] vec_v [N];
    logic [VEC_W-1:0] vec_bus;
    logic             irq_bus;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    assign en[0] = 1'b1;

    for (genvar i = 0; i < N; i++) begin : g_cell
        prio_chain_cell #(.VEC_W(VEC_W)) i_prio_chain_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .irq_req (req[i]),
            .en_in   (en[i]),
            .ack     (ack),
            .reti    (reti),
            .vec_cfg (7'(16 + i)),
            .irq_n   (irq_n_v[i]),
            .en_out  (en[i+1]),
            .vec_out (vec_v[i]),
            .vec_oe  (oe_v[i])
        );
    end

    always_comb begin
        vec_bus = '0;
        for (int k = 0; k < N; k++) vec_bus = vec_bus | vec_v[k];
        irq_bus = &irq_n_v;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // Acknowledge pulse: checks bus during the strobe, then clocks it.
    task automatic do_ack(input string tag, input logic [N-1:0] exp_oe,
                          input logic [VEC_W-1:0] exp_vec);
        ack = 1'b1;
        #1;
        chk({tag, " vec_oe"}, 32'(oe_v), 32'(exp_oe));
        chk({tag, " vec_bus"}, 32'(vec_bus), 32'(exp_vec));
        step();
        ack = 1'b0;
    endtask

    task automatic do_reti();
        reti = 1'b1;
        step();
        reti = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 irq idle", 32'(irq_bus), 1);
        chk("R1 R3 enable passes", 32'(en), 32'h1f);
        chk("R1 no vec_oe", 32'(oe_v), 0);
    endtask

    task automatic t_single();
        req[2] = 1'b1;
        step();
        chk("R2 request low", 32'(irq_bus), 0);
        chk("R4 pending blocks", 32'(en), 32'h07);
        step();
        do_ack("R5 single", 4'b0100, 8'h24);
        chk("R4 in service blocks", 32'(en), 32'h07);
        chk("R2 request released", 32'(irq_bus), 1);
        step();
        chk("R2 level no retrigger", 32'(irq_bus), 1);
        do_reti();
        chk("R7 service ended", 32'(en), 32'h1f);
        chk("R2 held level after reti", 32'(irq_bus), 1);
        req = '0;
        step();
    endtask

    task automatic t_ignore_idle();
        do_ack("R6 idle ack", 4'b0000, 8'h00);
        chk("R6 state after idle ack", 32'(en), 32'h1f);
        chk("R6 irq after idle ack", 32'(irq_bus), 1);
    endtask

    task automatic t_priority();
        req[1] = 1'b1;
        req[3] = 1'b1;
        step();
        chk("R11 request low", 32'(irq_bus), 0);
        do_ack("R11 top wins", 4'b0010, 8'h22);
        chk("R6 blocked cell silent", 32'(irq_bus), 1);
        do_ack("R6 blocked ack", 4'b0000, 8'h00);
        do_reti();
        chk("R7 lower now requests", 32'(irq_bus), 0);
        do_ack("R11 next cell", 4'b1000, 8'h26);
        do_reti();
        chk("R7 chain open", 32'(en), 32'h1f);
        req = '0;
        step();
    endtask

    task automatic t_nest();
        req[2] = 1'b1;
        step();
        do_ack("R5 outer", 4'b0100, 8'h24);
        req[0] = 1'b1;
        step();
        chk("R8 higher requests", 32'(irq_bus), 0);
        do_ack("R8 nested win", 4'b0001, 8'h20);
        chk("R4 nested blocks all", 32'(en), 32'h01);
        do_reti();
        chk("R7 inner cleared only", 32'(en), 32'h07);
        do_reti();
        chk("R7 outer cleared", 32'(en), 32'h1f);
        req = '0;
        step();
    endtask

    task automatic t_resvc();
        req[1] = 1'b1;
        step();
        do_ack("R5 first", 4'b0010, 8'h22);
        req[1] = 1'b0;
        step();
        req[1] = 1'b1;
        step();
        chk("R9 held while in service", 32'(irq_bus), 1);
        do_ack("R9 no answer in service", 4'b0000, 8'h00);
        do_reti();
        chk("R9 requests after service", 32'(irq_bus), 0);
        do_ack("R9 second service", 4'b0010, 8'h22);
        do_reti();
        chk("R9 chain open", 32'(en), 32'h1f);
        req = '0;
        step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        step();
        t_reset();
        t_single();
        t_ignore_idle();
        t_priority();
        t_nest();
        t_resvc();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule